// File: doc/BRIEF.md
# Two-Wire Register Slave with Persistent Pointer

This block is a slave on a two-wire serial bus (SCL clock, SDA data, open-drain). It oversamples both lines with the system clock, finds START and STOP conditions, and takes in a 7-bit device address followed by a direction bit. One input pin chooses which of two fixed device addresses the slave answers to. The first byte after an address in a write transfer is a command byte. It loads an internal pointer that selects one register of an external register file. Every following byte is written to the register that the pointer selects.

The pointer advances after each data byte, whether the byte is written or read. It keeps its value across STOP and repeated START. A master can therefore send only an address and a command byte, end the transfer, and later read a run of consecutive registers. It can also set the pointer and read in one transfer by using a repeated START. The register file sits outside the block and is reached through a plain write strobe and a combinational read port. Reads are addressed by the pointer. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2cps_top`

## Requirements
- R1: After reset the slave releases SDA (`sda_pull`=0), the pointer (`reg_addr`) is 0 and `reg_we` is low.
- R2: The slave acknowledges an address byte whose upper seven bits equal 0100000 when `addr_sel`=0, or 0100100 when `addr_sel`=1. It acknowledges by driving SDA low for the whole ninth clock. Bit 0 of the address byte is the direction bit, with 1 meaning read.
- R3: If the address byte does not match, the slave never drives SDA until the next START. In that case it writes nothing and leaves the pointer unchanged.
- R4: The first byte after a matching write address loads the pointer. The value is kept even when STOP follows the command byte directly.
- R5: Each write data byte is strobed on `reg_we` with `reg_wdata` at the current pointer. The pointer then advances by one.
- R6: The pointer wraps from NUM_REGS-1 to 0. A command value of NUM_REGS or more loads 0.
- R7: In a read, data bytes are sent MSB first, starting at the stored pointer. The pointer advances after each byte sent, so consecutive registers follow.
- R8: If the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R9: A repeated START returns the slave to address reception and leaves the pointer unchanged.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, SDA is released.
- R11: The slave acknowledges command and write data bytes on the ninth clock. During a read it releases SDA on the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Chooses between the two device addresses |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | PTR_W | Current pointer; register file address |
| reg_we | output | 1 | One-cycle write strobe to the register file |
| reg_wdata | output | 8 | Data byte written to the register file |
| reg_rdata | input | 8 | Register file content at `reg_addr` |

## Verification
The bench builds the block with ten registers and the default address pair. With ten registers, a short transfer reaches the wrap from register 9 back to 0 in both write and read, and command values above the register count can be tried. The bench drives `addr_sel` both ways, so each fixed address is seen accepted by one setting and rejected by the other. The bench's own model of the register file lets read-back follow pointer advance across STOP and repeated START.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e  state;
        logic [3:0]  cnt;
        logic [7:0]  shift;
        logic        rw;
        logic        mack;
        logic        pull;
    } slv_regs_t;

    typedef struct packed {
        logic [2:0] scl_h;
        logic [2:0] sda_h;
    } sync_regs_t;

endpackage

// File: rtl/i2cps_sync.sv
module i2cps_sync
    import i2cps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    sync_regs_t sy_d, sy_q;

    always_comb begin
        sy_d       = sy_q;
        sy_d.scl_h = {sy_q.scl_h[1:0], scl_i};
        sy_d.sda_h = {sy_q.sda_h[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.scl_h <= 3'b111;
            sy_q.sda_h <= 3'b111;
        end else begin
            sy_q <= sy_d;
        end
    end

    // bit 1 is the settled sample, bit 2 the one before it
    assign sda_s     = sy_q.sda_h[1];
    assign scl_rise  = sy_q.scl_h[1] & ~sy_q.scl_h[2];
    assign scl_fall  = ~sy_q.scl_h[1] & sy_q.scl_h[2];
    assign start_det = sy_q.scl_h[1] & sy_q.scl_h[2] & sy_q.sda_h[2] & ~sy_q.sda_h[1];
    assign stop_det  = sy_q.scl_h[1] & sy_q.scl_h[2] & ~sy_q.sda_h[2] & sy_q.sda_h[1];

    // R10: the two bus conditions never coincide
    assert_start_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

// File: rtl/i2cps_ptr.sv
module i2cps_ptr #(
    parameter int NUM_REGS = 10,
    localparam int PTR_W = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_val,
    input  logic             incr,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            if (int'(load_val) < NUM_REGS) ptr_d = load_val[PTR_W-1:0];
            else                           ptr_d = '0;
        end else if (incr) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R6: pointer never leaves the implemented range
    assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < NUM_REGS);

endmodule

// File: rtl/i2cps_top.sv
module i2cps_top
    import i2cps_pkg::*;
#(
    parameter int          NUM_REGS = 10,
    parameter logic [6:0]  ADDR_LO  = 7'b0100000,
    parameter logic [6:0]  ADDR_HI  = 7'b0100100,
    localparam int         PTR_W    = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    output logic             sda_pull,
    output logic [PTR_W-1:0] reg_addr,
    output logic             reg_we,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_load, ptr_inc;
    logic byte_done, addr_hit;
    slv_regs_t st_d, st_q;

    i2cps_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cps_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (st_q.shift),
        .incr     (ptr_inc),
        .ptr      (reg_addr)
    );

    assign byte_done = scl_fall && (st_q.cnt == 4'd8);
    assign addr_hit  = st_q.shift[7:1] == (addr_sel ? ADDR_HI : ADDR_LO);

    always_comb begin
        st_d     = st_q;
        reg_we   = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        if (stop_det) begin
            st_d.state = ST_IDLE;
            st_d.pull  = 1'b0;
        end else if (start_det) begin
            st_d.state = ST_ADDR;
            st_d.cnt   = '0;
            st_d.pull  = 1'b0;
        end else begin
            case (st_q.state)
                ST_ADDR, ST_CMD, ST_WDAT: begin
                    if (scl_rise) begin
                        st_d.shift = {st_q.shift[6:0], sda_s};
                        st_d.cnt   = st_q.cnt + 4'd1;
                    end else if (byte_done) begin
                        st_d.cnt  = '0;
                        st_d.pull = 1'b1;
                        if (st_q.state == ST_ADDR) begin
                            st_d.rw = st_q.shift[0];
                            if (addr_hit) st_d.state = ST_AACK;
                            else begin
                                st_d.state = ST_IDLE;
                                st_d.pull  = 1'b0;
                            end
                        end else if (st_q.state == ST_CMD) begin
                            ptr_load   = 1'b1;
                            st_d.state = ST_CACK;
                        end else begin
                            reg_we     = 1'b1;
                            ptr_inc    = 1'b1;
                            st_d.state = ST_WACK;
                        end
                    end
                end
                ST_AACK, ST_CACK, ST_WACK: begin
                    if (scl_fall) begin
                        st_d.pull = 1'b0;
                        st_d.cnt  = '0;
                        if (st_q.state == ST_AACK && st_q.rw) begin
                            st_d.state = ST_RDAT;
                            st_d.shift = reg_rdata;
                            st_d.pull  = ~reg_rdata[7];
                        end else if (st_q.state == ST_AACK) begin
                            st_d.state = ST_CMD;
                        end else begin
                            st_d.state = ST_WDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (byte_done) begin
                        st_d.pull  = 1'b0;
                        st_d.cnt   = '0;
                        ptr_inc    = 1'b1;
                        st_d.state = ST_RACK;
                    end else if (scl_fall) begin
                        st_d.shift = {st_q.shift[6:0], 1'b0};
                        st_d.pull  = ~st_q.shift[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.state = ST_RDAT;
                            st_d.shift = reg_rdata;
                            st_d.pull  = ~reg_rdata[7];
                        end else begin
                            st_d.state = ST_IDLE;
                        end
                    end
                end
                default: st_d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.shift <= '0;
            st_q.rw    <= 1'b0;
            st_q.mack  <= 1'b0;
            st_q.pull  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull  = st_q.pull;
    assign reg_wdata = st_q.shift;

    // R11: SDA drive only changes after SCL falls or a bus condition
    assert_pull_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

    // R10: STOP always frees the data line
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R5: a write strobe is followed by a one-step pointer advance with wrap
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == (($past(reg_addr) == LAST) ? '0 : $past(reg_addr) + 1'b1)));

    // R8: an idle slave never drives the line
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE) |-> !sda_pull);

endmodule

// File: tb/i2cps_top_tb.sv
module i2cps_top_tb;

    localparam int NR = 10;
    localparam int PW = 4;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_pull, reg_we;
    logic [PW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_bus;
    logic [7:0] mem [NR];
    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_en = 0;
    bit pull_seen = 0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign reg_rdata = mem[reg_addr];

    i2cps_top #(.NUM_REGS(NR)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_sel  (addr_sel),
        .sda_pull  (sda_pull),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (mon_en && sda_pull) pull_seen <= 1'b1;
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hw(Q);
        scl_m = 1'b1; hw(Q);
        sda_m = 1'b0; hw(Q);
        scl_m = 1'b0; hw(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hw(Q);
        scl_m = 1'b1; hw(Q);
        sda_m = 1'b1; hw(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(Q);
            scl_m = 1'b1; hw(2*Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hw(Q);
        scl_m = 1'b1; hw(Q);
        ack = !sda_bus;
        hw(Q);
        scl_m = 1'b0;
    endtask

    task automatic rbyte(input bit ack_m, output logic [7:0] v);
        v = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(Q);
            scl_m = 1'b1; hw(Q);
            v = {v[6:0], sda_bus};
            hw(Q);
            scl_m = 1'b0;
        end
        hw(1);
        sda_m = !ack_m; hw(Q);
        scl_m = 1'b1; hw(2*Q);
        scl_m = 1'b0; hw(Q);
        sda_m = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 sda_pull", int'(sda_pull), 0);
        chk("R1 reg_addr", int'(reg_addr), 0);
        chk("R1 reg_we", int'(reg_we), 0);
    endtask

    task automatic t_write;
        bit a;
        bus_start;
        wbyte(8'h40, a); chk("R2 addr ack sel0", int'(a), 1);
        wbyte(8'h03, a); chk("R11 cmd ack", int'(a), 1);
        wbyte(8'hA1, a); chk("R11 data ack", int'(a), 1);
        wbyte(8'hB2, a);
        bus_stop;
        chk("R5 mem3", int'(mem[3]), 'hA1);
        chk("R5 mem4", int'(mem[4]), 'hB2);
        chk("R5 ptr after two writes", int'(reg_addr), 5);
        chk("R10 released after stop", int'(sda_pull), 0);
    endtask

    task automatic t_cmd_only;
        bit a;
        bus_start;
        wbyte(8'h40, a);
        wbyte(8'h07, a);
        bus_stop;
        chk("R4 cmd kept after stop", int'(reg_addr), 7);
    endtask

    task automatic t_rstart_read;
        bit a;
        logic [7:0] v;
        bus_start;
        wbyte(8'h40, a);
        wbyte(8'h03, a);
        bus_start;
        chk("R9 ptr kept at repeated start", int'(reg_addr), 3);
        wbyte(8'h41, a); chk("R2 read addr ack", int'(a), 1);
        rbyte(1'b1, v); chk("R7 first read byte", int'(v), 'hA1);
        rbyte(1'b0, v); chk("R7 second read byte", int'(v), 'hB2);
        pull_seen = 0; mon_en = 1;
        wbyte(8'hFF, a);
        mon_en = 0;
        chk("R8 quiet after nack", int'(pull_seen), 0);
        bus_stop;
        chk("R7 ptr after reads", int'(reg_addr), 5);
    endtask

    task automatic t_bad_addr;
        bit a;
        pull_seen = 0; mon_en = 1;
        bus_start;
        wbyte(8'h48, a); chk("R3 no ack foreign addr", int'(a), 0);
        wbyte(8'h00, a);
        wbyte(8'h5A, a);
        bus_stop;
        mon_en = 0;
        chk("R3 never drove", int'(pull_seen), 0);
        chk("R3 ptr unchanged", int'(reg_addr), 5);
        chk("R3 mem5 untouched", int'(mem[5]), 0);
        chk("R3 mem0 untouched", int'(mem[0]), 0);
    endtask

    task automatic t_sel;
        bit a;
        addr_sel = 1'b1;
        bus_start;
        wbyte(8'h40, a); chk("R2 low addr rejected sel1", int'(a), 0);
        bus_stop;
        bus_start;
        wbyte(8'h48, a); chk("R2 high addr ack sel1", int'(a), 1);
        wbyte(8'h06, a);
        wbyte(8'h66, a);
        bus_stop;
        chk("R2 write via high addr", int'(mem[6]), 'h66);
        addr_sel = 1'b0;
    endtask

    task automatic t_wrap;
        bit a;
        logic [7:0] v;
        bus_start;
        wbyte(8'h40, a);
        wbyte(8'h09, a);
        wbyte(8'h99, a);
        wbyte(8'h10, a);
        bus_stop;
        chk("R6 mem9", int'(mem[9]), 'h99);
        chk("R6 wrapped write mem0", int'(mem[0]), 'h10);
        chk("R6 ptr after wrap", int'(reg_addr), 1);
        bus_start;
        wbyte(8'h40, a);
        wbyte(8'h09, a);
        bus_start;
        wbyte(8'h41, a);
        rbyte(1'b1, v); chk("R7 read last reg", int'(v), 'h99);
        rbyte(1'b0, v); chk("R6 read wraps to reg0", int'(v), 'h10);
        bus_stop;
        bus_start;
        wbyte(8'h40, a);
        wbyte(8'hC8, a);
        bus_stop;
        chk("R6 oversize cmd loads 0", int'(reg_addr), 0);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) mem[i] = 8'h00;
        hw(5);
        t_reset;
        rst_n = 1'b1;
        hw(5);
        t_reset;
        t_write;
        t_cmd_only;
        t_rstart_read;
        t_bad_addr;
        t_sel;
        t_wrap;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule